// File: doc/BRIEF.md
# Banked L1 Data-Array Access Arbiter

This block sits ahead of an L1 data array that is divided into eight 8-byte banks across each 64-byte line. In every cycle it may be offered two loads and one store. Each request gives the low address bits (line offset plus set index), a byte count of up to 16 and a valid bit. The block works out which banks each request covers. A request of up to 16 bytes that is not aligned can reach three consecutive banks, wrapping around inside the line. The block then decides which requests go ahead this cycle and issues per-bank read and write enables to the array. Each requester gets either a grant or a replay.

Two loads that hit a common bank go ahead together when they name the same set, because the bank reads one row for both. When their sets differ, load port 0 goes ahead and load port 1 is told to replay. Loads win over the store for any bank they both want. Each bank remembers whether its last access was a read or a write. After the direction changes, the bank stays idle for a parameterised number of cycles.

Loads carry no back-pressure: a load that cannot go ahead gets a replay pulse, and the requester presents it again. The store uses valid/ready. A store is taken when `st_valid` and `st_ready` are both high. If it cannot be served that cycle, the block keeps it and drops `st_ready`. The block then retries the kept store every cycle and ignores `st_valid`. `st_ready` returns high in the cycle after the kept store is written. All results are registered and appear in the cycle after the request.

Top module: `l1_bank_arbiter`

## Requirements
- R1: After the active-low synchronous reset, all enables, grants and replays are 0 and `st_ready` is 1. No store is held.
- R2: A request covers the banks from its start bank (address bits 5:3) through the bank that holds its last byte, wrapping modulo 8. Size 0 counts as 1 byte and sizes above 16 count as 16. The resulting enables appear one clock after the request.
- R3: Two valid loads that share a bank and have equal set indices (address bits 12:6) are both granted. `rd_en` is the union of their banks.
- R4: Two valid loads that share a bank but have different set indices produce a conflict. This holds even when their address bits 2 differ. Load 0 is granted and load 1 gets a replay.
- R5: Two loads with no bank in common are both granted, and up to six banks can be read in one cycle.
- R6: A load and a store that touch different banks are both granted in the same cycle. On a shared bank the load is granted and the store gets a replay. A bank is never read and written in the same cycle.
- R7: A store that is not served is kept. `st_ready` is low while it is kept, and `st_valid` is ignored during that time. The kept store is retried every cycle until it is written with its own banks, and then `st_ready` returns high.
- R8: When a bank changes direction, it stays idle for TURN cycles (default 2) after its last access. Back-to-back accesses in the same direction add no idle cycles.
- R9: A load that needs a bank still inside its write-to-read idle window gets a replay.
- R10: Every valid load gets exactly one of grant or replay in the next cycle. An idle port gets neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld0_valid | input | 1 | Load port 0 request valid |
| ld0_addr | input | 13 | Load port 0 byte address (set index and line offset) |
| ld0_size | input | 5 | Load port 0 byte count |
| ld1_valid | input | 1 | Load port 1 request valid |
| ld1_addr | input | 13 | Load port 1 byte address |
| ld1_size | input | 5 | Load port 1 byte count |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be accepted (no store held) |
| st_addr | input | 13 | Store byte address |
| st_size | input | 5 | Store byte count |
| rd_en | output | 8 | Per-bank read enable |
| wr_en | output | 8 | Per-bank write enable |
| ld0_grant | output | 1 | Load 0 served |
| ld0_replay | output | 1 | Load 0 must be reissued |
| ld1_grant | output | 1 | Load 1 served |
| ld1_replay | output | 1 | Load 1 must be reissued |
| st_grant | output | 1 | Store written |
| st_replay | output | 1 | Store deferred and held |

## Verification
The hardest case to reach is a kept store that is blocked by the idle window of its own bank. It must be retried across several cycles while a different store is waiting on `st_valid`. The stimulus sets this up with a load and a store to the same bank in one cycle, so the load turns the bank to read and the store is kept. It then removes the loads and offers a store to another bank. The bench checks for replays during the idle window, and then for a write with the kept store's bank pattern rather than the new store's.

// File: rtl/l1ba_pkg.sv
package l1ba_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/l1ba_span.sv
module l1ba_span #(
  parameter int NBANK      = 8,
  parameter int BANK_BYTES = 8,
  parameter int SIZE_W     = 5,
  parameter int MAX_SIZE   = 16,
  parameter int MAX_SPAN   = 3,
  localparam int OFF_W     = $clog2(BANK_BYTES),
  localparam int BSEL_W    = $clog2(NBANK)
) (
  input  logic [OFF_W+BSEL_W-1:0] offs,
  input  logic [SIZE_W-1:0]       size,
  output logic [NBANK-1:0]        mask
);
  localparam int CW = SIZE_W + 1;

  logic [CW-1:0]     eff;
  logic [CW-1:0]     last_off;
  logic [CW-1:0]     hi_bank;
  logic [BSEL_W-1:0] start;

  always_comb begin
    if (size == '0)                       eff = CW'(1);
    else if (CW'(size) > CW'(MAX_SIZE))   eff = CW'(MAX_SIZE);
    else                                  eff = CW'(size);
    start    = offs[OFF_W +: BSEL_W];
    last_off = CW'(offs[OFF_W-1:0]) + eff - CW'(1);
    hi_bank  = last_off >> OFF_W;
    mask     = '0;
    for (int j = 0; j < MAX_SPAN; j++) begin
      if (CW'(j) <= hi_bank) mask[BSEL_W'(32'(start) + j)] = 1'b1;
    end
  end
endmodule

// File: rtl/l1ba_bank_turn.sv
module l1ba_bank_turn
  import l1ba_pkg::*;
#(
  parameter int TURN = 2,
  localparam int CW  = $clog2(TURN + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go,
  input  logic wr_go,
  output logic rd_ok,
  output logic wr_ok
);
  dir_e          dir_q;
  logic [CW-1:0] cnt_q;

  assign rd_ok = (cnt_q == '0) || (dir_q == DIR_RD);
  assign wr_ok = (cnt_q == '0) || (dir_q == DIR_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= DIR_RD;
      cnt_q <= '0;
    end else if (rd_go || wr_go) begin
      dir_q <= wr_go ? DIR_WR : DIR_RD;
      cnt_q <= CW'(TURN);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/l1_bank_arbiter.sv
module l1_bank_arbiter #(
  parameter int NBANK      = 8,
  parameter int BANK_BYTES = 8,
  parameter int SET_W      = 7,
  parameter int SIZE_W     = 5,
  parameter int MAX_SIZE   = 16,
  parameter int TURN       = 2,
  localparam int OFF_W     = $clog2(BANK_BYTES),
  localparam int BSEL_W    = $clog2(NBANK),
  localparam int SET_LSB   = OFF_W + BSEL_W,
  localparam int ADDR_W    = SET_LSB + SET_W,
  localparam int MAX_SPAN  = (MAX_SIZE + BANK_BYTES - 2) / BANK_BYTES + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld0_valid,
  input  logic [ADDR_W-1:0] ld0_addr,
  input  logic [SIZE_W-1:0] ld0_size,
  input  logic              ld1_valid,
  input  logic [ADDR_W-1:0] ld1_addr,
  input  logic [SIZE_W-1:0] ld1_size,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SIZE_W-1:0] st_size,
  output logic [NBANK-1:0]  rd_en,
  output logic [NBANK-1:0]  wr_en,
  output logic              ld0_grant,
  output logic              ld0_replay,
  output logic              ld1_grant,
  output logic              ld1_replay,
  output logic              st_grant,
  output logic              st_replay
);
  localparam int NREQ = 3;

  logic [ADDR_W-1:0] req_addr [NREQ];
  logic [SIZE_W-1:0] req_size [NREQ];
  logic [NBANK-1:0]  req_mask [NREQ];

  assign req_addr[0] = ld0_addr;  assign req_size[0] = ld0_size;
  assign req_addr[1] = ld1_addr;  assign req_size[1] = ld1_size;
  assign req_addr[2] = st_addr;   assign req_size[2] = st_size;

  for (genvar k = 0; k < NREQ; k++) begin : g_span
    l1ba_span #(
      .NBANK(NBANK), .BANK_BYTES(BANK_BYTES), .SIZE_W(SIZE_W),
      .MAX_SIZE(MAX_SIZE), .MAX_SPAN(MAX_SPAN)
    ) u_span (
      .offs(req_addr[k][SET_LSB-1:0]),
      .size(req_size[k]),
      .mask(req_mask[k])
    );
  end

  // Per-bank direction tracking
  logic [NBANK-1:0] rd_ok, wr_ok, rd_go, wr_go;
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    l1ba_bank_turn #(.TURN(TURN)) u_turn (
      .clk(clk), .rst_n(rst_n),
      .rd_go(rd_go[b]), .wr_go(wr_go[b]),
      .rd_ok(rd_ok[b]), .wr_ok(wr_ok[b])
    );
  end

  // Held store
  logic             pend_q;
  logic [NBANK-1:0] pend_mask_q;

  logic             ld0_go, ld1_go, ld_clash, st_live, st_go;
  logic [NBANK-1:0] st_mask;

  always_comb begin
    ld_clash = ld0_valid && ld1_valid && ((req_mask[0] & req_mask[1]) != '0) &&
               (ld0_addr[SET_LSB +: SET_W] != ld1_addr[SET_LSB +: SET_W]);
    ld0_go   = ld0_valid && ((req_mask[0] & ~rd_ok) == '0);
    ld1_go   = ld1_valid && !ld_clash && ((req_mask[1] & ~rd_ok) == '0);
    rd_go    = (ld0_go ? req_mask[0] : '0) | (ld1_go ? req_mask[1] : '0);
    st_live  = pend_q || st_valid;
    st_mask  = pend_q ? pend_mask_q : req_mask[2];
    st_go    = st_live && ((st_mask & ~wr_ok) == '0) && ((st_mask & rd_go) == '0);
    wr_go    = st_go ? st_mask : '0;
  end

  assign st_ready = !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_mask_q <= '0;
      rd_en       <= '0;
      wr_en       <= '0;
      ld0_grant   <= 1'b0;
      ld0_replay  <= 1'b0;
      ld1_grant   <= 1'b0;
      ld1_replay  <= 1'b0;
      st_grant    <= 1'b0;
      st_replay   <= 1'b0;
    end else begin
      if (st_go) begin
        pend_q <= 1'b0;
      end else if (st_live) begin
        pend_q      <= 1'b1;
        pend_mask_q <= st_mask;
      end
      rd_en      <= rd_go;
      wr_en      <= wr_go;
      ld0_grant  <= ld0_go;
      ld0_replay <= ld0_valid && !ld0_go;
      ld1_grant  <= ld1_go;
      ld1_replay <= ld1_valid && !ld1_go;
      st_grant   <= st_go;
      st_replay  <= st_live && !st_go;
    end
  end
endmodule

// File: rtl/l1ba_checker.sv
module l1ba_checker #(
  parameter int NBANK  = 8,
  parameter int TURN   = 2,
  parameter int RD_MAX = 6,
  localparam int CW    = $clog2(TURN + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] rd_en,
  input logic [NBANK-1:0] wr_en,
  input logic             ld0_valid,
  input logic             ld0_grant,
  input logic             ld0_replay,
  input logic             ld1_valid,
  input logic             ld1_grant,
  input logic             ld1_replay,
  input logic             st_replay,
  input logic             st_ready
);
  assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en & wr_en) == '0);

  assert_read_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_en) <= RD_MAX);

  assert_held_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_replay |-> !st_ready);

  assert_ld0_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld0_valid |=> (ld0_grant != ld0_replay));
  assert_ld1_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld1_valid |=> (ld1_grant != ld1_replay));
  assert_ld0_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld0_valid |=> !(ld0_grant || ld0_replay));
  assert_ld1_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld1_valid |=> !(ld1_grant || ld1_replay));

  // Cycles since each bank was last seen read / written (saturating)
  for (genvar b = 0; b < NBANK; b++) begin : g_gap
    logic [CW-1:0] since_rd, since_wr;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        since_rd <= CW'(TURN);
        since_wr <= CW'(TURN);
      end else begin
        since_rd <= rd_en[b] ? '0 : ((since_rd == CW'(TURN)) ? since_rd : since_rd + CW'(1));
        since_wr <= wr_en[b] ? '0 : ((since_wr == CW'(TURN)) ? since_wr : since_wr + CW'(1));
      end
    end
    assert_rd_to_wr_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[b] |-> (since_rd >= CW'(TURN)));
    assert_wr_to_rd_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[b] |-> (since_wr >= CW'(TURN)));
  end
endmodule

bind l1_bank_arbiter l1ba_checker #(
  .NBANK(NBANK), .TURN(TURN), .RD_MAX(2 * MAX_SPAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
  .ld0_valid(ld0_valid), .ld0_grant(ld0_grant), .ld0_replay(ld0_replay),
  .ld1_valid(ld1_valid), .ld1_grant(ld1_grant), .ld1_replay(ld1_replay),
  .st_replay(st_replay), .st_ready(st_ready)
);

// File: tb/l1_bank_arbiter_tb.sv
`timescale 1ns/1ps
module l1_bank_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld0_valid = 0, ld1_valid = 0, st_valid = 0;
  logic [12:0] ld0_addr = '0, ld1_addr = '0, st_addr = '0;
  logic [4:0]  ld0_size = '0, ld1_size = '0, st_size = '0;
  logic        st_ready;
  logic [7:0]  rd_en, wr_en;
  logic        ld0_grant, ld0_replay, ld1_grant, ld1_replay, st_grant, st_replay;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  l1_bank_arbiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld0_valid(ld0_valid), .ld0_addr(ld0_addr), .ld0_size(ld0_size),
    .ld1_valid(ld1_valid), .ld1_addr(ld1_addr), .ld1_size(ld1_size),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_size(st_size),
    .rd_en(rd_en), .wr_en(wr_en),
    .ld0_grant(ld0_grant), .ld0_replay(ld0_replay),
    .ld1_grant(ld1_grant), .ld1_replay(ld1_replay),
    .st_grant(st_grant), .st_replay(st_replay)
  );

  // Compare all outputs: rd, wr, {g0,r0,g1,r1,gs,rs,ready}
  task automatic expect_out(string tag, logic [7:0] rd, logic [7:0] wr, logic [6:0] flags);
    logic [22:0] act, exp;
    act = {rd_en, wr_en, ld0_grant, ld0_replay, ld1_grant, ld1_replay, st_grant, st_replay, st_ready};
    exp = {rd, wr, flags};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual rd=%h wr=%h flags=%b expected rd=%h wr=%h flags=%b",
               tag, act[22:15], act[14:7], act[6:0], exp[22:15], exp[14:7], exp[6:0]);
    end
  endtask

  task automatic set_ld0(logic v, logic [12:0] a, logic [4:0] s);
    ld0_valid = v; ld0_addr = a; ld0_size = s;
  endtask
  task automatic set_ld1(logic v, logic [12:0] a, logic [4:0] s);
    ld1_valid = v; ld1_addr = a; ld1_size = s;
  endtask
  task automatic set_st(logic v, logic [12:0] a, logic [4:0] s);
    st_valid = v; st_addr = a; st_size = s;
  endtask

  task automatic idle(int n);
    set_ld0(0, '0, '0); set_ld1(0, '0, '0); set_st(0, '0, '0);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // flags: g0 r0 g1 r1 gs rs ready
  task automatic t_reset();
    expect_out("R1 reset state", 8'h00, 8'h00, 7'b000000_1);
  endtask

  task automatic t_span();
    set_ld0(1, 13'h000, 5'd8);  @(negedge clk);
    expect_out("R2 aligned 8B", 8'h01, 8'h00, 7'b100000_1);
    set_ld0(1, 13'h03C, 5'd16); @(negedge clk);
    expect_out("R2 wrap 7,0,1", 8'h83, 8'h00, 7'b100000_1);
    set_ld0(1, 13'h00D, 5'd16); @(negedge clk);
    expect_out("R2 three banks", 8'h0E, 8'h00, 7'b100000_1);
    set_ld0(1, 13'h028, 5'd0);  @(negedge clk);
    expect_out("R2 size0 as 1B", 8'h20, 8'h00, 7'b100000_1);
    set_ld0(1, 13'h000, 5'd31); @(negedge clk);
    expect_out("R2 size clamp 16", 8'h03, 8'h00, 7'b100000_1);
    idle(1);
    expect_out("R10 idle ports quiet", 8'h00, 8'h00, 7'b000000_1);
  endtask

  task automatic t_same_set();
    set_ld0(1, 13'h040, 5'd8); set_ld1(1, 13'h044, 5'd4); @(negedge clk);
    expect_out("R3 same set shares bank", 8'h01, 8'h00, 7'b101000_1);
    set_ld0(1, 13'h040, 5'd16); set_ld1(1, 13'h04C, 5'd8); @(negedge clk);
    expect_out("R3 union of banks", 8'h07, 8'h00, 7'b101000_1);
    idle(1);
  endtask

  task automatic t_diff_set();
    set_ld0(1, 13'h040, 5'd8); set_ld1(1, 13'h080, 5'd8); @(negedge clk);
    expect_out("R4 set conflict", 8'h01, 8'h00, 7'b100100_1);
    set_ld0(1, 13'h040, 5'd4); set_ld1(1, 13'h084, 5'd4); @(negedge clk);
    expect_out("R4 conflict bit2 differs", 8'h01, 8'h00, 7'b100100_1);
    idle(1);
  endtask

  task automatic t_disjoint();
    set_ld0(1, 13'h001, 5'd16); set_ld1(1, 13'h09D, 5'd16); @(negedge clk);
    expect_out("R5 six banks read", 8'h3F, 8'h00, 7'b101000_1);
    idle(4);
  endtask

  task automatic t_ld_st_disjoint();
    set_ld0(1, 13'h000, 5'd8); set_st(1, 13'h030, 5'd8); @(negedge clk);
    expect_out("R6 load and store split banks", 8'h01, 8'h40, 7'b100010_1);
    idle(4);
  endtask

  task automatic t_st_blocked();
    set_ld0(1, 13'h100, 5'd8); set_st(1, 13'h000, 5'd8); @(negedge clk);
    expect_out("R6 load wins shared bank", 8'h01, 8'h00, 7'b100001_0);
    set_ld0(0, '0, '0); set_st(1, 13'h038, 5'd8); @(negedge clk);
    expect_out("R7 held store in turnaround 1", 8'h00, 8'h00, 7'b000001_0);
    @(negedge clk);
    expect_out("R7 held store in turnaround 2", 8'h00, 8'h00, 7'b000001_0);
    @(negedge clk);
    expect_out("R7 held store written, new ignored", 8'h00, 8'h01, 7'b000010_1);
    idle(4);
  endtask

  task automatic t_turn();
    set_st(1, 13'h010, 5'd8); @(negedge clk);
    expect_out("R8 read-to-write after idle", 8'h00, 8'h04, 7'b000010_1);
    @(negedge clk);
    expect_out("R8 write back-to-back", 8'h00, 8'h04, 7'b000010_1);
    set_st(0, '0, '0); set_ld0(1, 13'h010, 5'd8); @(negedge clk);
    expect_out("R9 load blocked 1", 8'h00, 8'h00, 7'b010000_1);
    @(negedge clk);
    expect_out("R9 load blocked 2", 8'h00, 8'h00, 7'b010000_1);
    @(negedge clk);
    expect_out("R8 load after TURN idle", 8'h04, 8'h00, 7'b100000_1);
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_span();
    t_same_set();
    t_diff_set();
    t_disjoint();
    t_ld_st_disjoint();
    t_st_blocked();
    t_turn();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule